// File: doc/BRIEF.md
# Dual-Lane Multiply-Accumulate Unit

This block is a multiply-accumulate datapath with two 16-bit lanes and two 40-bit accumulators. In split operation each lane forms a signed 16x16 product and either loads it or adds it into its own accumulator. In fused operation the two lanes act as one signed 32x32 multiplier. The upper 32 bits of the 64-bit product are sign-extended and added into the low accumulator. The same cycle can also run a Viterbi add-compare-select step, or a parallel add on one lane and subtract on the other.

Every operation completes in one cycle and its result is registered, so it is visible at the outputs after the next rising edge. Three mode inputs control the arithmetic: fractional scaling, saturation to the signed 32-bit range, and rounding to the upper word. Multiply operations update four live flags: 32-bit overflow, 40-bit overflow, carry and non-negative. Two sticky overflow bits collect overflows until a clear strobe arrives.

Opcode encoding on `op_code`: 0 no-op, 1 split multiply-load, 2 split multiply-accumulate, 3 fused multiply-accumulate, 4 add-compare-select, 5 parallel add/subtract. Codes 6 and 7 behave as no-op.

Top module: `dual_mac_unit`

## Requirements
- R1: After a synchronous reset with `rst_n` low, both accumulators, `acs_dec`, all four live flags and both sticky flags read zero.
- R2: Split operation:
  - op 1 sets each accumulator to its lane's signed product.
  - op 2 adds the lane product to the accumulator's current value.
  - The lane pairs are (`opa_lo`, `opb_lo`) into `acc_lo` and (`opa_hi`, `opb_hi`) into `acc_hi`.
  - The result is visible after the next rising edge.
- R3: Fused operation (op 3):
  - The signed 32-bit operands are {`opa_hi`,`opa_lo`} and {`opb_hi`,`opb_lo`}.
  - Bits 63:32 of their 64-bit product, sign-extended to 40 bits, are added into `acc_lo`.
  - `acc_hi` is unchanged.
- R4: With `mode_frac` high, every product is doubled. Where both operands equal the most negative value, the doubled product is replaced by the largest positive value of its width: 0x7FFFFFFF for a lane, 0x7FFFFFFF in the upper word for fused operation.
- R5: Overflow flags and wrapping:
  - `flag_v` is set when the exact accumulation result lies outside the signed 32-bit range.
  - `flag_gv` is set when it lies outside the signed 40-bit range.
  - Without saturation the stored value is the exact result wrapped to 40 bits.
  - In split operation each flag is the OR over both lanes; in fused operation only the low lane counts.
- R6: With `mode_sat` high, a result outside the signed 32-bit range is clamped to 0x007FFFFFFF or 0xFF80000000 according to the sign of the exact result. `flag_v` is still set.
- R7: With `mode_rnd` high:
  - 0x8000 is added to the sum before the overflow checks.
  - When the result is not clamped, its bits 15:0 are cleared.
  - A clamped result keeps the exact limit value.
- R8: `flag_c` and `flag_ge`:
  - `flag_c` is the carry out of bit 39 of the unsigned sum of accumulator, product term and rounding constant. In split operation it is the OR over both lanes.
  - `flag_ge` is high when every written accumulator has bit 39 clear.
- R9: Sticky overflow flags:
  - `sticky_v` and `sticky_gv` are set by any multiply operation that raises the matching live flag.
  - They are cleared only by `sticky_clr`.
  - An overflow in the same cycle as `sticky_clr` leaves the sticky flag set.
- R10: Add-compare-select (op 4):
  - Form s0 = `opa_lo`+`opb_lo` and s1 = `opa_hi`+`opb_hi` as signed 17-bit sums.
  - Write the larger sum, sign-extended, to `acc_lo`.
  - Set `acs_dec` to 1 when s1 > s0, and to 0 on a tie or when s0 is larger.
  - `acs_dec` changes only on op 4, and `acc_hi` is unchanged.
- R11: Parallel add/subtract (op 5) writes `opa_lo`+`opb_lo` to `acc_lo` and `opa_hi`-`opb_hi` to `acc_hi`, each as signed sums sign-extended to 40 bits.
- R12: Ops 0, 4 and 5 leave the four live flags unchanged. Op 0 also leaves both accumulators unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| op_code | input | 3 | Operation select |
| opa_lo | input | 16 | Lane 0 operand A (low half of fused A) |
| opb_lo | input | 16 | Lane 0 operand B (low half of fused B) |
| opa_hi | input | 16 | Lane 1 operand A (high half of fused A) |
| opb_hi | input | 16 | Lane 1 operand B (high half of fused B) |
| mode_frac | input | 1 | Fractional product scaling |
| mode_sat | input | 1 | Saturate to signed 32-bit range |
| mode_rnd | input | 1 | Round to upper word |
| sticky_clr | input | 1 | Clear both sticky overflow flags |
| acc_lo | output | 40 | Lane 0 accumulator |
| acc_hi | output | 40 | Lane 1 accumulator |
| acs_dec | output | 1 | Last add-compare-select decision |
| flag_v | output | 1 | 32-bit overflow of last multiply operation |
| flag_gv | output | 1 | 40-bit overflow of last multiply operation |
| flag_c | output | 1 | Carry of last multiply operation |
| flag_ge | output | 1 | Last multiply result(s) non-negative |
| sticky_v | output | 1 | Accumulated 32-bit overflow |
| sticky_gv | output | 1 | Accumulated 40-bit overflow |

## Verification
The sticky clear strobe and an overflowing multiply-accumulate can land in the same cycle. When they do, the set must take priority over the clear. The bench first clears the sticky bit with a lone strobe. It then issues a fractional accumulate that exceeds the 32-bit range while asserting `sticky_clr`, and expects `sticky_v` high on the following cycle. A further clear paired with a non-overflowing multiply must then leave it low.

// File: rtl/dmac_pkg.sv
// Shared opcode and mode types for the dual-lane MAC unit.
package dmac_pkg;

    typedef enum logic [2:0] {
        OP_NOP    = 3'd0,
        OP_MPY16  = 3'd1,
        OP_MAC16  = 3'd2,
        OP_MAC32  = 3'd3,
        OP_ACS    = 3'd4,
        OP_ADDSUB = 3'd5
    } dmac_op_e;

    typedef struct packed {
        logic frac;
        logic sat;
        logic rnd;
    } dmac_mode_t;

endpackage

// File: rtl/dmac_mul.sv
// Product generator. Forms two signed LANE_W x LANE_W lane products and
// one signed 2*LANE_W x 2*LANE_W fused product, applies fractional
// doubling with clamping of the min*min case, and sign-extends each term
// to ACC_W bits. Assumes ACC_W >= 2*LANE_W. Purely combinational.
module dmac_mul #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [LANE_W-1:0] a_lo,
    input  logic [LANE_W-1:0] b_lo,
    input  logic [LANE_W-1:0] a_hi,
    input  logic [LANE_W-1:0] b_hi,
    input  logic              frac,
    input  logic              fuse,
    output logic [ACC_W-1:0]  term_lo,
    output logic [ACC_W-1:0]  term_hi
);
    localparam int PW = 2 * LANE_W;
    localparam int WW = 2 * PW;

    logic [1:0][LANE_W-1:0] a_v, b_v;
    logic [1:0][ACC_W-1:0]  split_t;
    logic signed [PW-1:0]   fa, fb;
    logic signed [WW-1:0]   wp;
    logic [ACC_W-1:0]       fused_t;

    assign a_v = {a_hi, a_lo};
    assign b_v = {b_hi, b_lo};

    for (genvar g = 0; g < 2; g++) begin : g_lane
        logic signed [LANE_W-1:0] sa, sb;
        logic signed [PW-1:0]     p;
        // Lane product with fractional doubling and min*min clamp.
        always_comb begin
            sa = a_v[g];
            sb = b_v[g];
            p  = sa * sb;
            if (frac && a_v[g] == {1'b1, {(LANE_W-1){1'b0}}}
                     && b_v[g] == {1'b1, {(LANE_W-1){1'b0}}})
                p = {1'b0, {(PW-1){1'b1}}};
            else if (frac)
                p = p <<< 1;
            split_t[g] = {{(ACC_W-PW){p[PW-1]}}, p};
        end
    end

    // Fused product; the upper word becomes the accumulation term.
    always_comb begin
        fa = {a_hi, a_lo};
        fb = {b_hi, b_lo};
        wp = fa * fb;
        if (frac && fa == {1'b1, {(PW-1){1'b0}}} && fb == {1'b1, {(PW-1){1'b0}}})
            wp = {1'b0, {(WW-1){1'b1}}};
        else if (frac)
            wp = wp <<< 1;
        fused_t = {{(ACC_W-PW){wp[WW-1]}}, wp[WW-1:PW]};
    end

    assign term_lo = fuse ? fused_t : split_t[0];
    assign term_hi = split_t[1];

endmodule

// File: rtl/dmac_acc.sv
// Accumulation stage for one lane: adds a product term (and rounding
// constant) to the accumulator or to zero, detects 2*LANE_W-bit and
// ACC_W-bit overflow on the exact sum, saturates and rounds.
// Assumes ACC_W > 2*LANE_W. Purely combinational.
module dmac_acc #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [ACC_W-1:0] acc_in,
    input  logic [ACC_W-1:0] term,
    input  logic             acc_en,
    input  logic             sat,
    input  logic             rnd,
    output logic [ACC_W-1:0] res,
    output logic             ovf_n,
    output logic             ovf_w,
    output logic             carry,
    output logic             nonneg
);
    localparam int XW = ACC_W + 2;
    localparam int NW = 2 * LANE_W;
    localparam logic [ACC_W-1:0] NMAX = {{(ACC_W-NW+1){1'b0}}, {(NW-1){1'b1}}};
    localparam logic [ACC_W-1:0] NMIN = {{(ACC_W-NW+1){1'b1}}, {(NW-1){1'b0}}};

    logic [ACC_W-1:0] base, rconst;
    logic [XW-1:0]    exact, usum;

    // Exact signed sum, unsigned carry sum, range checks, clamp and round.
    always_comb begin
        base   = acc_en ? acc_in : '0;
        rconst = rnd ? (ACC_W'(1) << (LANE_W-1)) : '0;
        exact  = {{2{base[ACC_W-1]}}, base} + {{2{term[ACC_W-1]}}, term}
               + {2'b00, rconst};
        usum   = {2'b00, base} + {2'b00, term} + {2'b00, rconst};
        carry  = |usum[XW-1:ACC_W];
        ovf_w  = !((&exact[XW-1:ACC_W-1]) || !(|exact[XW-1:ACC_W-1]));
        ovf_n  = !((&exact[XW-1:NW-1])    || !(|exact[XW-1:NW-1]));
        if (sat && ovf_n) begin
            res = exact[XW-1] ? NMIN : NMAX;
        end else begin
            res = exact[ACC_W-1:0];
            if (rnd) res[LANE_W-1:0] = '0;
        end
        nonneg = !res[ACC_W-1];
    end

endmodule

// File: rtl/dmac_simd.sv
// Non-multiply lane operations: add-compare-select across both lanes and
// parallel add (lane 0) / subtract (lane 1). Results are sign-extended to
// ACC_W bits. Assumes ACC_W > LANE_W. Purely combinational.
module dmac_simd #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic [LANE_W-1:0] a_lo,
    input  logic [LANE_W-1:0] b_lo,
    input  logic [LANE_W-1:0] a_hi,
    input  logic [LANE_W-1:0] b_hi,
    output logic [ACC_W-1:0]  acs_res,
    output logic              acs_sel,
    output logic [ACC_W-1:0]  add_res,
    output logic [ACC_W-1:0]  sub_res
);
    localparam int SW = LANE_W + 1;

    logic signed [SW-1:0] s0, s1, d1;

    // Both lane sums, the lane-1 difference, and the select of the larger sum.
    always_comb begin
        s0      = $signed({a_lo[LANE_W-1], a_lo}) + $signed({b_lo[LANE_W-1], b_lo});
        s1      = $signed({a_hi[LANE_W-1], a_hi}) + $signed({b_hi[LANE_W-1], b_hi});
        d1      = $signed({a_hi[LANE_W-1], a_hi}) - $signed({b_hi[LANE_W-1], b_hi});
        acs_sel = s1 > s0;
        acs_res = acs_sel ? {{(ACC_W-SW){s1[SW-1]}}, s1} : {{(ACC_W-SW){s0[SW-1]}}, s0};
        add_res = {{(ACC_W-SW){s0[SW-1]}}, s0};
        sub_res = {{(ACC_W-SW){d1[SW-1]}}, d1};
    end

endmodule

// File: rtl/dual_mac_unit.sv
// Dual-lane multiply-accumulate unit. Decodes the opcode, routes lane or
// fused products through two accumulation stages, and registers the
// accumulators, ACS decision, live flags and sticky overflow flags.
// Assumes a synchronous active-low reset held for at least one edge.
module dual_mac_unit #(
    parameter int LANE_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_code,
    input  logic [LANE_W-1:0] opa_lo,
    input  logic [LANE_W-1:0] opb_lo,
    input  logic [LANE_W-1:0] opa_hi,
    input  logic [LANE_W-1:0] opb_hi,
    input  logic              mode_frac,
    input  logic              mode_sat,
    input  logic              mode_rnd,
    input  logic              sticky_clr,
    output logic [ACC_W-1:0]  acc_lo,
    output logic [ACC_W-1:0]  acc_hi,
    output logic              acs_dec,
    output logic              flag_v,
    output logic              flag_gv,
    output logic              flag_c,
    output logic              flag_ge,
    output logic              sticky_v,
    output logic              sticky_gv
);
    import dmac_pkg::*;

    localparam int NW = 2 * LANE_W;

    dmac_op_e         op_e;
    dmac_mode_t       mode;
    logic             mac_op, split_op, fuse_op;
    logic [ACC_W-1:0] acc_q [2];
    logic [ACC_W-1:0] acc_d [2];
    logic [ACC_W-1:0] term [2];
    logic [ACC_W-1:0] lres [2];
    logic [1:0]       lv, lgv, lc, lge;
    logic             v_now, gv_now, c_now, ge_now;
    logic [ACC_W-1:0] acs_res, add_res, sub_res;
    logic             acs_sel;

    assign op_e     = dmac_op_e'(op_code);
    assign mode     = '{frac: mode_frac, sat: mode_sat, rnd: mode_rnd};
    assign split_op = (op_e == OP_MPY16) || (op_e == OP_MAC16);
    assign fuse_op  = (op_e == OP_MAC32);
    assign mac_op   = split_op || fuse_op;

    dmac_mul #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_mul (
        .a_lo(opa_lo), .b_lo(opb_lo), .a_hi(opa_hi), .b_hi(opb_hi),
        .frac(mode.frac), .fuse(fuse_op),
        .term_lo(term[0]), .term_hi(term[1])
    );

    for (genvar g = 0; g < 2; g++) begin : g_acc
        dmac_acc #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_acc (
            .acc_in(acc_q[g]), .term(term[g]),
            .acc_en(op_e != OP_MPY16),
            .sat(mode.sat), .rnd(mode.rnd),
            .res(lres[g]), .ovf_n(lv[g]), .ovf_w(lgv[g]),
            .carry(lc[g]), .nonneg(lge[g])
        );
    end

    dmac_simd #(.LANE_W(LANE_W), .ACC_W(ACC_W)) u_simd (
        .a_lo(opa_lo), .b_lo(opb_lo), .a_hi(opa_hi), .b_hi(opb_hi),
        .acs_res(acs_res), .acs_sel(acs_sel),
        .add_res(add_res), .sub_res(sub_res)
    );

    // Flag values of the current multiply, merged over the active lanes.
    always_comb begin
        v_now  = lv[0]  || (split_op && lv[1]);
        gv_now = lgv[0] || (split_op && lgv[1]);
        c_now  = lc[0]  || (split_op && lc[1]);
        ge_now = lge[0] && (!split_op || lge[1]);
    end

    // Next accumulator values by opcode.
    always_comb begin
        acc_d[0] = acc_q[0];
        acc_d[1] = acc_q[1];
        unique case (op_e)
            OP_MPY16, OP_MAC16: begin
                acc_d[0] = lres[0];
                acc_d[1] = lres[1];
            end
            OP_MAC32:  acc_d[0] = lres[0];
            OP_ACS:    acc_d[0] = acs_res;
            OP_ADDSUB: begin
                acc_d[0] = add_res;
                acc_d[1] = sub_res;
            end
            default: ;
        endcase
    end

    // State registers: accumulators, decision, live and sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q[0]  <= '0;
            acc_q[1]  <= '0;
            acs_dec   <= 1'b0;
            flag_v    <= 1'b0;
            flag_gv   <= 1'b0;
            flag_c    <= 1'b0;
            flag_ge   <= 1'b0;
            sticky_v  <= 1'b0;
            sticky_gv <= 1'b0;
        end else begin
            acc_q[0] <= acc_d[0];
            acc_q[1] <= acc_d[1];
            if (op_e == OP_ACS) acs_dec <= acs_sel;
            if (mac_op) begin
                flag_v  <= v_now;
                flag_gv <= gv_now;
                flag_c  <= c_now;
                flag_ge <= ge_now;
            end
            sticky_v  <= (sticky_v  && !sticky_clr) || (mac_op && v_now);
            sticky_gv <= (sticky_gv && !sticky_clr) || (mac_op && gv_now);
        end
    end

    assign acc_lo = acc_q[0];
    assign acc_hi = acc_q[1];

    // R5: a 40-bit overflow is also a 32-bit overflow
    p_gv_implies_v_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flag_gv |-> flag_v);

    // R12: non-multiply ops leave the live flags alone
    p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !mac_op |=> $stable({flag_v, flag_gv, flag_c, flag_ge}));

    // R9: an overflowing multiply always leaves the sticky flag set
    p_sticky_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_op && v_now) |=> sticky_v);

    // R9: the sticky flag only rises together with the live flag
    p_sticky_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sticky_v) |-> flag_v);

    // R3: fused multiply and ACS do not touch the high accumulator
    p_hi_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e == OP_MAC32 || op_e == OP_ACS) |=> $stable(acc_hi));

    // R6: saturated multiplies leave the low accumulator in 32-bit range
    p_sat_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mac_op && mode_sat) |=> ((&acc_lo[ACC_W-1:NW-1]) || !(|acc_lo[ACC_W-1:NW-1])));

    // R10: the decision bit changes only on an ACS op
    p_dec_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (op_e != OP_ACS) |=> $stable(acs_dec));

endmodule

// File: tb/tb_dual_mac_unit.sv
`timescale 1ns/1ps
module tb_dual_mac_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic [15:0] opa_lo = '0, opb_lo = '0, opa_hi = '0, opb_hi = '0;
    logic        mode_frac = 1'b0, mode_sat = 1'b0, mode_rnd = 1'b0, sticky_clr = 1'b0;
    logic [39:0] acc_lo, acc_hi;
    logic        acs_dec, flag_v, flag_gv, flag_c, flag_ge, sticky_v, sticky_gv;
    int          checks = 0;
    int          errors = 0;

    always #2.5 clk = ~clk;

    dual_mac_unit dut (
        .clk(clk), .rst_n(rst_n), .op_code(op_code),
        .opa_lo(opa_lo), .opb_lo(opb_lo), .opa_hi(opa_hi), .opb_hi(opb_hi),
        .mode_frac(mode_frac), .mode_sat(mode_sat), .mode_rnd(mode_rnd),
        .sticky_clr(sticky_clr),
        .acc_lo(acc_lo), .acc_hi(acc_hi), .acs_dec(acs_dec),
        .flag_v(flag_v), .flag_gv(flag_gv), .flag_c(flag_c), .flag_ge(flag_ge),
        .sticky_v(sticky_v), .sticky_gv(sticky_gv)
    );

    task automatic chk(input string req, input string what,
                       input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Apply one operation for one edge; return at the next falling edge.
    task automatic do_op(input logic [2:0] op, input logic [15:0] a0, input logic [15:0] b0,
                         input logic [15:0] a1, input logic [15:0] b1,
                         input logic fr, input logic st, input logic rn, input logic cl);
        op_code = op; opa_lo = a0; opb_lo = b0; opa_hi = a1; opb_hi = b1;
        mode_frac = fr; mode_sat = st; mode_rnd = rn; sticky_clr = cl;
        @(negedge clk);
        op_code = 3'd0; sticky_clr = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk("R1", "acc_lo", acc_lo, 40'h0);
        chk("R1", "acc_hi", acc_hi, 40'h0);
        chk("R1", "flags+dec", {34'h0, acs_dec, flag_v, flag_gv, flag_c, flag_ge, sticky_v}, 40'h0);
        chk("R1", "sticky_gv", {39'h0, sticky_gv}, 40'h0);
    endtask

    task automatic t_split_int;
        do_op(3'd1, 16'd3, 16'hFFFC, 16'd100, 16'd200, 0, 0, 0, 0);
        chk("R2", "mpy lo", acc_lo, 40'hFFFFFFFFF4);
        chk("R2", "mpy hi", acc_hi, 40'd20000);
        chk("R8", "c/ge after mpy", {38'h0, flag_c, flag_ge}, 40'h0);
        do_op(3'd2, 16'd2, 16'd5, 16'd1, 16'd1, 0, 0, 0, 0);
        chk("R2", "mac lo", acc_lo, 40'hFFFFFFFFFE);
        chk("R2", "mac hi", acc_hi, 40'd20001);
        do_op(3'd2, 16'd1, 16'd5, 16'd0, 16'd0, 0, 0, 0, 0);
        chk("R2", "mac lo to positive", acc_lo, 40'd3);
        chk("R8", "carry and ge set", {38'h0, flag_c, flag_ge}, 40'h3);
    endtask

    task automatic t_frac;
        do_op(3'd1, 16'h4000, 16'h4000, 16'h8000, 16'h8000, 1, 0, 0, 0);
        chk("R4", "half*half", acc_lo, 40'h0020000000);
        chk("R4", "min*min clamp", acc_hi, 40'h007FFFFFFF);
        chk("R4", "no overflow", {39'h0, flag_v}, 40'h0);
    endtask

    task automatic t_wrap;
        do_op(3'd1, 16'h8000, 16'h8000, 16'h0, 16'h0, 1, 0, 0, 0);
        do_op(3'd2, 16'h8000, 16'h8000, 16'h0, 16'h0, 1, 0, 0, 0);
        chk("R5", "beyond 32 bits kept", acc_lo, 40'h00FFFFFFFE);
        chk("R5", "v set gv clear", {38'h0, flag_v, flag_gv}, 40'h2);
        chk("R9", "sticky_v set", {39'h0, sticky_v}, 40'h1);
    endtask

    task automatic t_sticky;
        do_op(3'd0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0, 0, 1);
        chk("R9", "cleared by strobe", {39'h0, sticky_v}, 40'h0);
        chk("R12", "nop keeps flag_v", {39'h0, flag_v}, 40'h1);
        do_op(3'd2, 16'h8000, 16'h8000, 16'h0, 16'h0, 1, 0, 0, 1);
        chk("R9", "overflow wins over clear", {39'h0, sticky_v}, 40'h1);
        do_op(3'd1, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0, 0, 1);
        chk("R9", "clear with quiet mpy", {38'h0, sticky_v, flag_v}, 40'h0);
    endtask

    task automatic t_sat;
        do_op(3'd1, 16'h8000, 16'h8000, 16'h0, 16'h0, 1, 1, 0, 0);
        do_op(3'd2, 16'h8000, 16'h8000, 16'h0, 16'h0, 1, 1, 0, 0);
        chk("R6", "positive clamp", acc_lo, 40'h007FFFFFFF);
        chk("R6", "v still set", {39'h0, flag_v}, 40'h1);
        do_op(3'd1, 16'h8000, 16'h7FFF, 16'h0, 16'h0, 0, 1, 0, 0);
        chk("R2", "neg product", acc_lo, 40'hFFC0008000);
        do_op(3'd2, 16'h8000, 16'h7FFF, 16'h0, 16'h0, 0, 1, 0, 0);
        chk("R6", "in range not clamped", acc_lo, 40'hFF80010000);
        chk("R6", "no v in range", {39'h0, flag_v}, 40'h0);
        do_op(3'd2, 16'h8000, 16'h7FFF, 16'h0, 16'h0, 0, 1, 0, 0);
        chk("R6", "negative clamp", acc_lo, 40'hFF80000000);
        chk("R8", "v set, ge clear", {38'h0, flag_v, flag_ge}, 40'h2);
    endtask

    task automatic t_round;
        do_op(3'd1, 16'h0100, 16'h0081, 16'h0001, 16'h7FFF, 0, 0, 1, 0);
        chk("R7", "round up lo", acc_lo, 40'h0000010000);
        chk("R7", "round down hi", acc_hi, 40'h0);
        do_op(3'd1, 16'h8000, 16'h8000, 16'h0, 16'h0, 1, 1, 1, 0);
        chk("R7", "round then clamp", acc_lo, 40'h007FFFFFFF);
        chk("R7", "round overflow v", {39'h0, flag_v}, 40'h1);
    endtask

    task automatic t_fused;
        do_op(3'd1, 16'h0, 16'h0, 16'd2, 16'd3, 0, 0, 0, 0);
        do_op(3'd3, 16'h0, 16'h0, 16'h0001, 16'h0003, 0, 0, 0, 0);
        chk("R3", "upper word of 3<<32", acc_lo, 40'd3);
        chk("R3", "hi acc untouched", acc_hi, 40'd6);
        do_op(3'd3, 16'hFFFF, 16'h0005, 16'hFFFF, 16'h0000, 0, 0, 0, 0);
        chk("R3", "negative upper word", acc_lo, 40'd2);
    endtask

    task automatic t_gv;
        do_op(3'd1, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0, 0, 0);
        for (int i = 0; i < 256; i++) begin
            do_op(3'd3, 16'h0, 16'h0, 16'h8000, 16'h8000, 1, 0, 0, 0);
            if (i == 0) chk("R4", "fused min*min clamp", acc_lo, 40'h007FFFFFFF);
        end
        chk("R5", "near 40-bit limit", acc_lo, 40'h7FFFFFFF00);
        chk("R5", "v without gv", {38'h0, flag_v, flag_gv}, 40'h2);
        do_op(3'd3, 16'h0, 16'h0, 16'h8000, 16'h8000, 1, 0, 0, 0);
        chk("R5", "40-bit wrap", acc_lo, 40'h807FFFFEFF);
        chk("R5", "gv set", {39'h0, flag_gv}, 40'h1);
        chk("R8", "no carry, ge clear", {38'h0, flag_c, flag_ge}, 40'h0);
        chk("R9", "sticky_gv set", {39'h0, sticky_gv}, 40'h1);
        chk("R3", "hi acc after fused run", acc_hi, 40'h0);
        do_op(3'd0, 16'h0, 16'h0, 16'h0, 16'h0, 0, 0, 0, 1);
        chk("R9", "sticky_gv cleared", {39'h0, sticky_gv}, 40'h0);
    endtask

    task automatic t_acs;
        logic [3:0]  fl;
        logic [39:0] hi;
        fl = {flag_v, flag_gv, flag_c, flag_ge};
        hi = acc_hi;
        do_op(3'd4, 16'd10, 16'hFFFD, 16'd2, 16'd4, 0, 0, 0, 0);
        chk("R10", "lane0 wins", acc_lo, 40'd7);
        chk("R10", "dec 0", {39'h0, acs_dec}, 40'h0);
        do_op(3'd4, 16'd10, 16'hFFFD, 16'd5, 16'd4, 0, 0, 0, 0);
        chk("R10", "lane1 wins", acc_lo, 40'd9);
        chk("R10", "dec 1", {39'h0, acs_dec}, 40'h1);
        do_op(3'd0, 16'd0, 16'd0, 16'd0, 16'd0, 0, 0, 0, 0);
        chk("R10", "dec held on nop", {39'h0, acs_dec}, 40'h1);
        do_op(3'd4, 16'h8000, 16'h8000, 16'hFFFF, 16'h0, 0, 0, 0, 0);
        chk("R10", "negative sums", acc_lo, 40'hFFFFFFFFFF);
        do_op(3'd4, 16'd1, 16'd1, 16'd2, 16'd0, 0, 0, 0, 0);
        chk("R10", "tie picks lane0", {acc_lo[38:0], acs_dec}, {39'd2, 1'b0});
        chk("R10", "hi acc untouched", acc_hi, hi);
        chk("R12", "flags kept by acs", {36'h0, flag_v, flag_gv, flag_c, flag_ge}, {36'h0, fl});
    endtask

    task automatic t_addsub;
        logic [3:0] fl;
        fl = {flag_v, flag_gv, flag_c, flag_ge};
        do_op(3'd5, 16'h7FFF, 16'h0001, 16'h8000, 16'h0001, 1, 1, 1, 0);
        chk("R11", "add lane", acc_lo, 40'h0000008000);
        chk("R11", "sub lane", acc_hi, 40'hFFFFFF7FFF);
        chk("R12", "flags kept by addsub", {36'h0, flag_v, flag_gv, flag_c, flag_ge}, {36'h0, fl});
    endtask

    task automatic t_nop;
        logic [39:0] lo, hi;
        lo = acc_lo; hi = acc_hi;
        do_op(3'd0, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 1, 1, 1, 0);
        do_op(3'd7, 16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 0, 0, 0, 0);
        chk("R12", "nop lo", acc_lo, lo);
        chk("R12", "nop hi", acc_hi, hi);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_split_int();
        t_frac();
        t_wrap();
        t_sticky();
        t_sat();
        t_round();
        t_fused();
        t_gv();
        t_acs();
        t_addsub();
        t_nop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule